// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a serial receiver/transmitter pair and two external character FIFOs. It takes received characters, break indications and host data-register accesses, and steers each one to the receive FIFO, the transmit FIFO, both, or neither. The choice depends on a 2-bit channel mode: normal, echo, local loopback or remote loopback.

The block holds the control register. Its enable and disable bits gate every FIFO access, and its two FIFO-flush bits clear themselves. The block flags a character that finds its target FIFO full, and it raises a receive-timeout event once enough character times have passed without new receive data.

The FIFOs are outside the block. The block drives their push, pop and clear strobes, and it reads their fill levels and the head byte of the receive FIFO.

Top module: `chan_route`

## Requirements
- R1: The mode code is 2'b00 normal, 2'b01 echo, 2'b10 local loopback, 2'b11 remote loopback. A received character (`rx_valid`) is pushed to the RX FIFO in normal and echo modes, and to the TX FIFO in echo and remote loopback modes. In local loopback it goes nowhere.
- R2: A host data write (`host_wr`) is pushed to the TX FIFO in normal mode and to the RX FIFO in local loopback mode. It is dropped in echo and remote loopback modes.
- R3: RX FIFO pushes and pops occur only while control bit 2 is 1 and bit 3 is 0. TX FIFO pushes occur only while bit 4 is 1 and bit 5 is 0. A push blocked by these bits disappears without an overrun.
- R4: An enabled push into a FIFO whose level equals the depth (64) is discarded. `ovr_evt` is high in that same cycle.
- R5: `rx_ready` is low exactly when a FIFO that received characters are routed to in the current mode is full.
- R6: A `brk_det` pulse pushes a zero byte into the RX FIFO in every mode, as long as RX is enabled, and the received character of that cycle is ignored. In local loopback, a host write in the same cycle takes the RX FIFO slot and the break is dropped.
- R7: A host read (`host_rd`) with RX enabled and a nonzero RX level asserts `rxf_pop` in the same cycle and presents `rxf_head` on `host_rdata` in the next cycle. Any other host read gives no pop, and `host_rdata` is zero in the next cycle.
- R8: After reset, `ctrl_q` reads 9'h128: both directions disabled, with bit 8 set.
- R9: Writing 1 to control bit 0 (or bit 1) gives a one-cycle `rxf_clr` (or `txf_clr`) pulse in the following cycle. Those bits always read back as 0, and the other written bits are stored.
- R10: While `rto_cfg` is nonzero, `rto_evt` pulses for one cycle right after the 4th `char_tick` that follows the most recent RX FIFO push. Each RX push restarts the count. A zero `rto_cfg` suppresses the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mode | input | 2 | Channel mode code |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control register write data |
| ctrl_q | output | 9 | Control register contents |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | Receiver may deliver a character |
| brk_det | input | 1 | Break condition received |
| host_wr | input | 1 | Host data register write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host data register read strobe |
| host_rdata | output | 8 | Host read data, one cycle after the read |
| rxf_push | output | 1 | RX FIFO push |
| rxf_wdata | output | 8 | RX FIFO push data |
| rxf_pop | output | 1 | RX FIFO pop |
| rxf_head | input | 8 | RX FIFO head byte |
| rxf_level | input | 7 | RX FIFO fill level |
| rxf_clr | output | 1 | RX FIFO flush pulse |
| txf_push | output | 1 | TX FIFO push |
| txf_wdata | output | 8 | TX FIFO push data |
| txf_level | input | 7 | TX FIFO fill level |
| txf_clr | output | 1 | TX FIFO flush pulse |
| char_tick | input | 1 | One pulse per character time |
| rto_cfg | input | 8 | Receive timeout setting, zero disables |
| ovr_evt | output | 1 | Overrun event |
| rto_evt | output | 1 | Receive timeout event |

## Verification
The bench uses the default parameters: depth 64, 8-bit characters, a four-character timeout and registered read data. With a depth of 64, the full condition is reached simply by driving a level of 64 on the level ports, so overrun and ready behaviour in every mode can be tested without filling a real FIFO. Because the timeout is four character times, a complete restart-and-expire sequence fits in a few dozen cycles, including a restart just before expiry.

// File: rtl/chan_route_pkg.sv
package chan_route_pkg;

   typedef enum logic [1:0] {
      CM_NORMAL = 2'b00,
      CM_ECHO   = 2'b01,
      CM_LLOOP  = 2'b10,
      CM_RLOOP  = 2'b11
   } chan_mode_e;

   localparam int CTRL_W       = 9;
   localparam int CB_RXFLUSH   = 0;
   localparam int CB_TXFLUSH   = 1;
   localparam int CB_RXON      = 2;
   localparam int CB_RXOFF     = 3;
   localparam int CB_TXON      = 4;
   localparam int CB_TXOFF     = 5;
   localparam int CB_BRKHOLD   = 8;

   localparam logic [CTRL_W-1:0] CTRL_RESET =
      CTRL_W'((1 << CB_RXOFF) | (1 << CB_TXOFF) | (1 << CB_BRKHOLD));

endpackage

// File: rtl/chan_route_ctrl.sv
module chan_route_ctrl
   import chan_route_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] q,
   output logic              rx_en,
   output logic              tx_en,
   output logic              rx_clr,
   output logic              tx_clr
);

   localparam logic [CTRL_W-1:0] FLUSH_MASK =
      CTRL_W'((1 << CB_RXFLUSH) | (1 << CB_TXFLUSH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= CTRL_RESET;
         rx_clr <= 1'b0;
         tx_clr <= 1'b0;
      end else begin
         rx_clr <= we & wdata[CB_RXFLUSH];
         tx_clr <= we & wdata[CB_TXFLUSH];
         if (we) q <= wdata & ~FLUSH_MASK;
      end
   end

   assign rx_en = q[CB_RXON] & ~q[CB_RXOFF];
   assign tx_en = q[CB_TXON] & ~q[CB_TXOFF];

   // R9
   self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[CB_RXFLUSH]) |=> (rx_clr && !q[CB_RXFLUSH]));

   // R9
   flush_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q[CB_RXFLUSH] == 1'b0 && q[CB_TXFLUSH] == 1'b0));

endmodule

// File: rtl/chan_route_steer.sv
module chan_route_steer
   import chan_route_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int LVL_W = $clog2(DEPTH + 1)
)(
   input  logic [1:0]        mode,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              brk,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  tx_level,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_wdata,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_wdata,
   output logic              ovr,
   output logic              rdy
);

   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   logic rcv_to_rx, rcv_to_tx, hw_to_rx, hw_to_tx;
   logic rx_full, tx_full;
   logic char_ok, req_host_rx, req_brk, req_char_rx, req_rx;
   logic req_host_tx, req_char_tx, req_tx;

   always_comb begin
      rcv_to_rx = (mode == CM_NORMAL) || (mode == CM_ECHO);
      rcv_to_tx = (mode == CM_ECHO)   || (mode == CM_RLOOP);
      hw_to_tx  = (mode == CM_NORMAL);
      hw_to_rx  = (mode == CM_LLOOP);
   end

   assign rx_full = (rx_level == FULL_LVL);
   assign tx_full = (tx_level == FULL_LVL);

   assign char_ok     = rx_valid & ~brk;
   assign req_host_rx = host_wr & hw_to_rx;
   assign req_brk     = brk & ~req_host_rx;
   assign req_char_rx = char_ok & rcv_to_rx;
   assign req_rx      = req_host_rx | req_brk | req_char_rx;

   assign req_host_tx = host_wr & hw_to_tx;
   assign req_char_tx = char_ok & rcv_to_tx;
   assign req_tx      = req_host_tx | req_char_tx;

   always_comb begin
      if (req_host_rx)  rx_wdata = host_wdata;
      else if (req_brk) rx_wdata = '0;
      else              rx_wdata = rx_data;
      tx_wdata = req_host_tx ? host_wdata : rx_data;
   end

   assign rx_push = req_rx & rx_en & ~rx_full;
   assign tx_push = req_tx & tx_en & ~tx_full;
   assign ovr     = (req_rx & rx_en & rx_full) | (req_tx & tx_en & tx_full);
   assign rdy     = ~((rcv_to_rx & rx_full) | (rcv_to_tx & tx_full));

endmodule

// File: rtl/chan_route_rto.sv
module chan_route_rto #(
   parameter int TO_CHARS = 4,
   parameter int CFG_W    = 8,
   localparam int CNT_W   = $clog2(TO_CHARS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [CFG_W-1:0] cfg,
   output logic             evt
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CHARS - 1);

   logic             armed;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
         evt   <= 1'b0;
      end else begin
         evt <= 1'b0;
         if (restart) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (armed && tick) begin
            if (cnt == LAST) begin
               armed <= 1'b0;
               cnt   <= '0;
               evt   <= (cfg != '0);
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R10
   rto_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);

   // R10
   rto_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !evt);

endmodule

// File: rtl/chan_route.sv
module chan_route
   import chan_route_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 64,
   parameter int TO_CHARS  = 4,
   parameter int CFG_W     = 8,
   parameter bit RDATA_REG = 1'b1,
   localparam int LVL_W    = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        chan_mode,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   input  logic              brk_det,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              rxf_push,
   output logic [DATA_W-1:0] rxf_wdata,
   output logic              rxf_pop,
   input  logic [DATA_W-1:0] rxf_head,
   input  logic [LVL_W-1:0]  rxf_level,
   output logic              rxf_clr,
   output logic              txf_push,
   output logic [DATA_W-1:0] txf_wdata,
   input  logic [LVL_W-1:0]  txf_level,
   output logic              txf_clr,
   input  logic              char_tick,
   input  logic [CFG_W-1:0]  rto_cfg,
   output logic              ovr_evt,
   output logic              rto_evt
);

   generate
      if (DEPTH < 2)    $error("chan_route: DEPTH must be at least 2");
      if (DATA_W < 5)   $error("chan_route: DATA_W must be at least 5");
      if (TO_CHARS < 1) $error("chan_route: TO_CHARS must be at least 1");
   endgenerate

   logic rx_en, tx_en;

   chan_route_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctrl_we),
      .wdata  (ctrl_wdata),
      .q      (ctrl_q),
      .rx_en  (rx_en),
      .tx_en  (tx_en),
      .rx_clr (rxf_clr),
      .tx_clr (txf_clr)
   );

   chan_route_steer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_steer (
      .mode       (chan_mode),
      .rx_en      (rx_en),
      .tx_en      (tx_en),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .brk        (brk_det),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .rx_level   (rxf_level),
      .tx_level   (txf_level),
      .rx_push    (rxf_push),
      .rx_wdata   (rxf_wdata),
      .tx_push    (txf_push),
      .tx_wdata   (txf_wdata),
      .ovr        (ovr_evt),
      .rdy        (rx_ready)
   );

   chan_route_rto #(.TO_CHARS(TO_CHARS), .CFG_W(CFG_W)) u_rto (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rxf_push),
      .tick    (char_tick),
      .cfg     (rto_cfg),
      .evt     (rto_evt)
   );

   assign rxf_pop = host_rd & rx_en & (rxf_level != '0);

   generate
      if (RDATA_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       host_rdata <= '0;
            else if (host_rd) host_rdata <= rxf_pop ? rxf_head : '0;
         end
         // R7
         empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rd && (rxf_level == '0)) |=> (host_rdata == '0));
      end else begin : g_rd_comb
         assign host_rdata = rxf_pop ? rxf_head : '0;
      end
   endgenerate

   // R3
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_push || rxf_pop) |-> (ctrl_q[CB_RXON] && !ctrl_q[CB_RXOFF]));

   // R3
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txf_push |-> (ctrl_q[CB_TXON] && !ctrl_q[CB_TXOFF]));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_push |-> (rxf_level != LVL_W'(DEPTH))) and
      (txf_push |-> (txf_level != LVL_W'(DEPTH))));

   // R1
   lloop_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_mode == CM_LLOOP) |-> !txf_push);

endmodule

// File: tb/chan_route_test.sv
module chan_route_test;

   localparam int DW = 8;
   localparam int DEPTH = 64;
   localparam int LW = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] chan_mode = 2'b00;
   logic ctrl_we = 1'b0;
   logic [8:0] ctrl_wdata = '0;
   logic [8:0] ctrl_q;
   logic rx_valid = 1'b0;
   logic [DW-1:0] rx_data = 8'hA5;
   logic rx_ready;
   logic brk_det = 1'b0;
   logic host_wr = 1'b0;
   logic [DW-1:0] host_wdata = 8'h3C;
   logic host_rd = 1'b0;
   logic [DW-1:0] host_rdata;
   logic rxf_push, rxf_pop, rxf_clr, txf_push, txf_clr;
   logic [DW-1:0] rxf_wdata, txf_wdata;
   logic [DW-1:0] rxf_head = 8'h77;
   logic [LW-1:0] rxf_level = '0;
   logic [LW-1:0] txf_level = '0;
   logic char_tick = 1'b0;
   logic [7:0] rto_cfg = '0;
   logic ovr_evt, rto_evt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   chan_route uut (
      .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .brk_det(brk_det), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata),
      .rxf_push(rxf_push), .rxf_wdata(rxf_wdata), .rxf_pop(rxf_pop),
      .rxf_head(rxf_head), .rxf_level(rxf_level), .rxf_clr(rxf_clr),
      .txf_push(txf_push), .txf_wdata(txf_wdata), .txf_level(txf_level),
      .txf_clr(txf_clr), .char_tick(char_tick), .rto_cfg(rto_cfg),
      .ovr_evt(ovr_evt), .rto_evt(rto_evt)
   );

   // {mode[14:13], rxen, txen, rxv, hwr, brk, rxfull, txfull,
   //  exp_rxpush, exp_txpush, exp_ovr, exp_ready, src[1:0]}  src: 0 rx, 1 host, 2 zero
   localparam int NV = 17;
   localparam logic [14:0] VEC [NV] = '{
      {2'b00, 7'b1110000, 4'b1001, 2'd0},
      {2'b00, 7'b1101000, 4'b0101, 2'd0},
      {2'b01, 7'b1110000, 4'b1101, 2'd0},
      {2'b01, 7'b1101000, 4'b0001, 2'd0},
      {2'b10, 7'b1110000, 4'b0001, 2'd0},
      {2'b10, 7'b1101000, 4'b1001, 2'd1},
      {2'b11, 7'b1110000, 4'b0101, 2'd0},
      {2'b11, 7'b1101000, 4'b0001, 2'd0},
      {2'b00, 7'b1110010, 4'b0010, 2'd0},
      {2'b01, 7'b1110001, 4'b1010, 2'd0},
      {2'b00, 7'b0110000, 4'b0001, 2'd0},
      {2'b00, 7'b1001000, 4'b0001, 2'd0},
      {2'b11, 7'b1100100, 4'b1001, 2'd2},
      {2'b10, 7'b1101100, 4'b1001, 2'd1},
      {2'b00, 7'b1110100, 4'b1001, 2'd2},
      {2'b11, 7'b1110010, 4'b0101, 2'd0},
      {2'b10, 7'b1101010, 4'b0011, 2'd1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [8:0] v);
      @(negedge clk);
      ctrl_we = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         char_tick = 1'b1;
         @(negedge clk);
         char_tick = 1'b0;
      end
   endtask

   task automatic push_char;
      @(negedge clk);
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset value
      check("R8 ctrl reset", 32'(ctrl_q), 32'h128);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 ctrl after release", 32'(ctrl_q), 32'h128);
      // R3: disabled at reset, receive pushes nothing and no overrun
      rx_valid = 1'b1;
      #1;
      check("R3 no push while disabled", {30'd0, rxf_push, ovr_evt}, 32'd0);
      rx_valid = 1'b0;

      // vector table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         logic [14:0] e;
         logic [8:0] cw;
         logic [DW-1:0] exp_rxd;
         logic [DW-1:0] exp_txd;
         e = VEC[v];
         cw = 9'h000;
         cw = cw | (e[12] ? 9'h004 : 9'h008);
         cw = cw | (e[11] ? 9'h010 : 9'h020);
         wr_ctrl(cw);
         @(negedge clk);
         chan_mode = e[14:13];
         rx_valid  = e[10];
         host_wr   = e[9];
         brk_det   = e[8];
         rxf_level = e[7] ? LW'(DEPTH) : LW'(10);
         txf_level = e[6] ? LW'(DEPTH) : LW'(10);
         #1;
         check($sformatf("R1/R2/R3 rx push vec%0d", v), 32'(rxf_push), 32'(e[5]));
         check($sformatf("R1/R2/R3 tx push vec%0d", v), 32'(txf_push), 32'(e[4]));
         check($sformatf("R4 overrun vec%0d", v), 32'(ovr_evt), 32'(e[3]));
         check($sformatf("R5 ready vec%0d", v), 32'(rx_ready), 32'(e[2]));
         exp_rxd = (e[1:0] == 2'd1) ? host_wdata : (e[1:0] == 2'd2) ? 8'h00 : rx_data;
         exp_txd = (e[14:13] == 2'b00) ? host_wdata : rx_data;
         if (e[5]) check($sformatf("R6 rx data vec%0d", v), 32'(rxf_wdata), 32'(exp_rxd));
         if (e[4]) check($sformatf("R2 tx data vec%0d", v), 32'(txf_wdata), 32'(exp_txd));
         rx_valid = 1'b0; host_wr = 1'b0; brk_det = 1'b0;
         rxf_level = '0; txf_level = '0;
      end
      chan_mode = 2'b00;

      // R9: self-clearing flush bits
      wr_ctrl(9'h017);
      check("R9 rx clr pulse", 32'(rxf_clr), 32'd1);
      check("R9 tx clr pulse", 32'(txf_clr), 32'd1);
      check("R9 readback", 32'(ctrl_q), 32'h014);
      @(negedge clk);
      check("R9 clr ends", {30'd0, rxf_clr, txf_clr}, 32'd0);

      // R7: host reads
      @(negedge clk);
      host_rd = 1'b1; rxf_level = LW'(5);
      #1 check("R7 pop", 32'(rxf_pop), 32'd1);
      @(negedge clk);
      host_rd = 1'b0;
      check("R7 rdata head", 32'(host_rdata), 32'h77);
      host_rd = 1'b1; rxf_level = '0;
      #1 check("R7 no pop empty", 32'(rxf_pop), 32'd0);
      @(negedge clk);
      host_rd = 1'b0;
      check("R7 rdata empty zero", 32'(host_rdata), 32'd0);
      wr_ctrl(9'h018);
      @(negedge clk);
      host_rd = 1'b1; rxf_level = LW'(5);
      #1 check("R7 no pop disabled", 32'(rxf_pop), 32'd0);
      @(negedge clk);
      host_rd = 1'b0; rxf_level = '0;
      check("R7 rdata disabled zero", 32'(host_rdata), 32'd0);

      // R10: receive timeout
      wr_ctrl(9'h014);
      rto_cfg = 8'd5;
      push_char();
      tick_n(3);
      check("R10 no evt after 3", 32'(rto_evt), 32'd0);
      tick_n(1);
      check("R10 evt after 4", 32'(rto_evt), 32'd1);
      @(negedge clk);
      check("R10 evt one cycle", 32'(rto_evt), 32'd0);
      push_char();
      tick_n(3);
      push_char();
      tick_n(3);
      check("R10 restart holds off", 32'(rto_evt), 32'd0);
      tick_n(1);
      check("R10 evt after restart", 32'(rto_evt), 32'd1);
      rto_cfg = 8'd0;
      push_char();
      tick_n(4);
      check("R10 zero cfg suppresses", 32'(rto_evt), 32'd0);
      tick_n(2);
      check("R10 stays idle", 32'(rto_evt), 32'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule